// File: doc/BRIEF.md
# Two-Pass Halving Lowpass FIR

This block is the last filtering stage of a receive-side resampling chain. It takes a stream of signed 16-bit samples, each marked by a one-cycle valid strobe, and filters them with a lowpass FIR. It keeps only every second filtered result, so the output rate is half the accepted input rate. The taps come from a parameter array of signed 16-bit Q1.15 values.

The upstream stage never raises valid on two consecutive cycles. The block relies on that spacing to run each multiplier twice per sample. In the cycle a sample arrives, the multipliers work on the lower half of the taps. In the next cycle, they work on the upper half. The two partial sums go into one full-precision accumulator. The block therefore needs half as many multipliers as taps.

Upstream valid timing can be irregular, with gaps of any length of one idle cycle or more. Output valid follows the same irregular timing, delayed by a fixed latency.

Top module: `srcdec_fir`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `out_valid` is 0 and `out_data` is 0.
- R2: A phase bit starts at 0 after reset and flips on every accepted input. Accepted inputs are numbered n = 0, 1, 2, … from reset. Only inputs with even n produce an output, giving exactly one output per two accepted inputs.
- R3: The output for accepted input n is computed from y = Σ COEFS[k]·x[n−k] for k = 0 … NTAPS−1. Samples accepted before the most recent reset count as zero.
- R4: The sum y is a full-precision value in units of 2^-15. It is rounded to nearest by computing floor((y + 2^14) / 2^15), so exact ties round toward positive infinity.
- R5: The rounded value is saturated to the range −32768 … 32767 before it is presented on `out_data`.
- R6: An input with even n is sampled at clock edge k. At edge k+2, `out_valid` rises for exactly one cycle, with the result on `out_data`. At all other times `out_valid` is 0.
- R7: Results do not depend on how many idle cycles (one or more) separate accepted inputs. `in_data` has no effect while `in_valid` is 0.
- R8: A synchronous reset in the middle of a stream drops any result still in flight. It also clears the sample history and the phase bit, so the next accepted input is again input n = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe; never high on two consecutive cycles |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle strobe marking a filtered, decimated result |
| out_data | output | 16 | Signed rounded and saturated result |

## Verification
The bench builds the block with NTAPS = 8 and a custom tap set. That tap set includes a half-scale tap at position 0, a full-scale negative tap, and a DC gain slightly above one. With the half-scale tap, a single sample of +1 or −1 just after reset lands exactly on a rounding tie. With the DC gain above one, steady full-scale inputs of either sign drive the accumulator past both output limits. A behavioural model keeps the accepted history in a queue and recomputes each expected result. It compares `out_valid` and `out_data` on every cycle through impulses, randomly spaced random data, saturating runs and a reset in the middle of a stream.

// File: rtl/srcdec_pkg.sv
package srcdec_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 15;
    localparam int PROD_W    = SAMPLE_W + COEF_W;
    // Headroom for up to 256 taps at full scale
    localparam int ACC_W     = PROD_W + 8;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [PROD_W-1:0]   prod_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    localparam acc_t OUT_MAX    = acc_t'(2**(SAMPLE_W-1) - 1);
    localparam acc_t OUT_MIN    = acc_t'(-(2**(SAMPLE_W-1)));
    localparam acc_t ROUND_HALF = acc_t'(2**(COEF_FRAC-1));

    // Two-pass schedule of the shared multipliers
    typedef enum logic [1:0] {
        STG_IDLE = 2'd0,
        STG_HI   = 2'd1,
        STG_DONE = 2'd2
    } mac_stage_e;

    typedef struct packed {
        logic valid;
        acc_t sum;
    } mac_res_t;

    // Round half up at the Q15 boundary, then clamp to the sample range
    function automatic sample_t round_sat(input acc_t a);
        acc_t r;
        r = (a + ROUND_HALF) >>> COEF_FRAC;
        if (r > OUT_MAX)      return sample_t'(OUT_MAX);
        else if (r < OUT_MIN) return sample_t'(OUT_MIN);
        else                  return sample_t'(r);
    endfunction

endpackage

// File: rtl/srcdec_tap_line.sv
module srcdec_tap_line
    import srcdec_pkg::*;
#(
    parameter int NTAPS = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  sample_t in_data,
    output sample_t win_lo [NTAPS/2],
    output sample_t win_hi [NTAPS/2],
    output logic    phase
);
    localparam int HALF = NTAPS / 2;

    sample_t taps [NTAPS];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 1'b0;
            for (int k = 0; k < NTAPS; k++) taps[k] <= '0;
        end else if (in_valid) begin
            phase   <= ~phase;
            taps[0] <= in_data;
            for (int k = 1; k < NTAPS; k++) taps[k] <= taps[k-1];
        end
    end

    // Lower window: the arriving sample plus the newest stored ones
    assign win_lo[0] = in_data;
    generate
        for (genvar j = 1; j < HALF; j++) begin : g_lo
            assign win_lo[j] = taps[j-1];
        end
        // Upper window is read one cycle later, after the shift
        for (genvar j = 0; j < HALF; j++) begin : g_hi
            assign win_hi[j] = taps[HALF+j];
        end
    endgenerate

    a_r2_phase_toggle: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (phase != $past(phase)));

    a_r7_input_spacing: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> !in_valid);

endmodule

// File: rtl/srcdec_mac.sv
module srcdec_mac
    import srcdec_pkg::*;
#(
    parameter int    NTAPS = 16,
    parameter coef_t COEFS [NTAPS] = '{default: '0}
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  sample_t  win_lo [NTAPS/2],
    input  sample_t  win_hi [NTAPS/2],
    output mac_res_t res
);
    localparam int HALF = NTAPS / 2;

    mac_stage_e stage_q;
    acc_t       acc_q;
    acc_t       partial;
    logic       use_hi;
    prod_t      prod [HALF];

    assign use_hi = (stage_q == STG_HI);

    generate
        for (genvar j = 0; j < HALF; j++) begin : g_mul
            sample_t op_x;
            coef_t   op_c;
            assign op_x    = use_hi ? win_hi[j] : win_lo[j];
            assign op_c    = use_hi ? COEFS[HALF+j] : COEFS[j];
            assign prod[j] = prod_t'(op_x) * prod_t'(op_c);
        end
    endgenerate

    always_comb begin
        partial = '0;
        for (int j = 0; j < HALF; j++) partial = partial + acc_t'(prod[j]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= STG_IDLE;
            acc_q   <= '0;
        end else if (start) begin
            stage_q <= STG_HI;
            acc_q   <= partial;
        end else if (stage_q == STG_HI) begin
            stage_q <= STG_DONE;
            acc_q   <= acc_q + partial;
        end else begin
            stage_q <= STG_IDLE;
        end
    end

    assign res.valid = (stage_q == STG_DONE);
    assign res.sum   = acc_q;

    // R6: a finished sum always traces back to a start two cycles earlier
    a_r6_two_pass: assert property (@(posedge clk) disable iff (rst)
        res.valid |-> $past(start, 2));

    a_r3_no_restart_mid_pass: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

endmodule

// File: rtl/srcdec_out.sv
module srcdec_out
    import srcdec_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  mac_res_t res,
    output logic     out_valid,
    output sample_t  out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= res.valid;
            if (res.valid) out_data <= round_sat(res.sum);
        end
    end

    a_r5_clip_high: assert property (@(posedge clk) disable iff (rst)
        ($past(res.valid) && ($past(res.sum) >= (OUT_MAX <<< COEF_FRAC)))
        |-> (out_data == sample_t'(OUT_MAX)));

    a_r5_clip_low: assert property (@(posedge clk) disable iff (rst)
        ($past(res.valid) && ($past(res.sum) < (OUT_MIN <<< COEF_FRAC)))
        |-> (out_data == sample_t'(OUT_MIN)));

endmodule

// File: rtl/srcdec_fir.sv
module srcdec_fir
    import srcdec_pkg::*;
#(
    parameter int    NTAPS = 16,
    parameter coef_t COEFS [NTAPS] = '{
        -16'sd80,   -16'sd240,  16'sd160,   16'sd900,
        -16'sd300,  -16'sd2200, 16'sd3900,  16'sd14300,
        16'sd14300, 16'sd3900,  -16'sd2200, -16'sd300,
        16'sd900,   16'sd160,   -16'sd240,  -16'sd80
    }
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    input  logic signed [srcdec_pkg::SAMPLE_W-1:0] in_data,
    output logic                              out_valid,
    output logic signed [srcdec_pkg::SAMPLE_W-1:0] out_data
);
    localparam int HALF = NTAPS / 2;

    sample_t  win_lo [HALF];
    sample_t  win_hi [HALF];
    logic     phase;
    logic     start;
    mac_res_t res;

    srcdec_tap_line #(.NTAPS(NTAPS)) u_taps (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .win_lo   (win_lo),
        .win_hi   (win_hi),
        .phase    (phase)
    );

    // Only even-numbered accepted inputs launch a computation
    assign start = in_valid & ~phase;

    srcdec_mac #(.NTAPS(NTAPS), .COEFS(COEFS)) u_mac (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .win_lo (win_lo),
        .win_hi (win_hi),
        .res    (res)
    );

    srcdec_out u_out (
        .clk       (clk),
        .rst       (rst),
        .res       (res),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    a_r6_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 3));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r8_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);

endmodule

// File: tb/test_srcdec_fir.sv
`timescale 1ns/1ps
module test_srcdec_fir;
    import srcdec_pkg::*;

    localparam int NT = 8;
    localparam coef_t TB_COEFS [NT] = '{
        16'sd16384, -16'sd8192, 16'sd32767, 16'sd4096,
        16'sh8000,  16'sd1000,  16'sd20000, -16'sd300
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_data = '0;
    logic               out_valid;
    logic signed [15:0] out_data;

    srcdec_fir #(.NTAPS(NT), .COEFS(TB_COEFS)) i_srcdec_fir (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #2.5 clk = ~clk;

    int     edge_cnt = 0;
    longint hist [$];
    int     exp_due [$];
    int     exp_val [$];
    int     checks = 0;
    int     errors = 0;
    string  cur_req = "R3";
    int     last_out = 0;
    int     out_count = 0;
    int     sat_hi = 0;
    int     sat_lo = 0;

    function automatic int model_out();
        longint s = 0;
        longint r;
        int n = hist.size() - 1;
        for (int k = 0; k < NT; k++)
            if (n - k >= 0) s += longint'(TB_COEFS[k]) * hist[n-k];
        r = (s + 64'sd16384) >>> 15;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model: samples inputs at the edge (inputs change at negedge)
    always @(posedge clk) begin
        edge_cnt++;
        if (rst) begin
            hist.delete();
            exp_due.delete();
            exp_val.delete();
        end else if (in_valid) begin
            hist.push_back(longint'(in_data));
            if (hist.size() % 2 == 1) begin
                exp_due.push_back(edge_cnt + 2);
                exp_val.push_back(model_out());
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            check_eq("R8 valid low in reset", int'(out_valid), 0);
        end else begin
            logic exp_v;
            exp_v = (exp_due.size() > 0) && (exp_due[0] == edge_cnt);
            check_eq("R6 valid timing", int'(out_valid), int'(exp_v));
            if (exp_v) begin
                check_eq(cur_req, int'(out_data), exp_val[0]);
                void'(exp_due.pop_front());
                void'(exp_val.pop_front());
            end
            if (out_valid) begin
                last_out = int'(out_data);
                out_count++;
                if (out_data == 16'sd32767) sat_hi++;
                if (out_data == -16'sd32768) sat_lo++;
            end
        end
    end

    task automatic send(input int x, input int gap);
        in_valid = 1'b1;
        in_data  = 16'(x);
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < gap; i++) begin
            in_data = 16'($urandom);   // R7: junk on idle cycles
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        check_eq("R1 out_valid in reset", int'(out_valid), 0);
        check_eq("R1 out_data in reset", int'(out_data), 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1 out_valid after release", int'(out_valid), 0);
        check_eq("R1 out_data after release", int'(out_data), 0);

        // R4: tie cases with the half-scale tap 0
        cur_req = "R4";
        send(1, 4);
        check_eq("R4 +0.5 ties upward", last_out, 1);
        check_eq("R2 first input yields output", out_count, 1);
        do_reset();
        send(-1, 4);
        check_eq("R4 -0.5 ties upward", last_out, 0);

        // R3: impulse with regular spacing
        do_reset();
        cur_req = "R3";
        base = out_count;
        send(1000, 1);
        for (int i = 0; i < 8; i++) send(0, 1);
        repeat (4) @(negedge clk);
        check_eq("R2 nine inputs give five outputs", out_count - base, 5);

        // R7: irregular spacing, random data
        cur_req = "R7";
        base = out_count;
        for (int i = 0; i < 60; i++)
            send(int'($urandom_range(0, 2000)) - 1000, int'($urandom_range(1, 5)));
        repeat (4) @(negedge clk);
        check_eq("R2 sixty inputs give thirty outputs", out_count - base, 30);

        // R5: full-scale runs of both signs
        cur_req = "R5";
        for (int i = 0; i < 10; i++) send(32767, 1);
        for (int i = 0; i < 10; i++) send(-32768, 2);
        repeat (4) @(negedge clk);
        check_eq("R5 positive clip seen", int'(sat_hi > 0), 1);
        check_eq("R5 negative clip seen", int'(sat_lo > 0), 1);

        // R8: reset while a result is in flight
        cur_req = "R8";
        do_reset();
        send(300, 1);
        send(400, 1);
        send(500, 1);
        base = out_count;
        do_reset();
        check_eq("R8 in-flight result dropped", out_count - base, 0);
        send(5, 4);
        check_eq("R8 phase restarts at zero", out_count - base, 1);
        check_eq("R8 history cleared", last_out, 3);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule